// File: doc/BRIEF.md
# Buffer RAM Pointer Access Port

This block gives a host processor byte access to a 2048 x 8 buffer RAM through three locations of a small 8-bit register bus. Two of the locations form a pointer: the upper byte carries the top three address bits together with a direction flag and an auto-advance flag, and the lower byte carries the bottom eight address bits. The third location is a data window. Each access to the window reads or writes the RAM byte at the pointer and, when auto-advance is on, moves the pointer to the next byte.

The direction is fixed before any data moves. This lets the read path fetch a byte into a holding register ahead of time. When the pointer is loaded in read direction, the port fetches the addressed byte at once. Every window read returns the held byte and, with auto-advance on, fetches the following one. A host copying a frame out of the buffer sets the pointer once and then reads the window back to back. Between two window accesses it leaves at least one idle bus cycle.

Top module: `bufram_ptr_port`

## Requirements
- R1: After reset the pointer is 0x000, the direction is write and auto-advance is off, so both pointer locations (register address 0 and 1) read back 0x00.
- R2: A write to register address 0 sets the direction from bit 7 (1 = read, 0 = write), auto-advance from bit 6, and pointer bits 10..8 from bits 2..0; reading address 0 returns these fields in the same positions.
- R3: Bits 5..3 of register address 0 always read back as 0, whatever was written.
- R4: A write to register address 1 sets pointer bits 7..0; reading address 1 returns pointer bits 7..0.
- R5: In write direction, a write to the data window (register address 2) stores the byte at RAM[pointer].
- R6: In read direction, writing register address 1 fetches RAM[new pointer] into the holding register on the next clock edge, so a window read issued after one idle cycle returns that byte.
- R7: In read direction, a window read returns the holding register; with auto-advance on, the pointer then advances by one and the next byte is fetched on the following edge.
- R8: With auto-advance off, window accesses leave the pointer unchanged: repeated reads return the same byte, and repeated writes overwrite the same location.
- R9: An advance from 0x7FF goes to 0x000, and the carry reaches the address bits of register address 0, for both window reads and window writes.
- R10: A window access against the set direction is ignored: a write in read direction changes neither the RAM nor the pointer, and a read in write direction does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register select: 0 pointer upper, 1 pointer lower, 2 data window, 3 unused (reads 0) |
| regWdata | input | 8 | Write data from the host |
| regRd | input | 1 | Read strobe, one cycle per access |
| regWr | input | 1 | Write strobe, one cycle per access |
| regRdata | output | 8 | Read data, valid combinationally while the register is addressed |

## Verification
The hardest case to reach is the pointer wrapping from the last byte back to zero while a prefetch is in flight. Here the carry has to reach the upper pointer byte, and the fetched byte has to come from address zero and not from past the end. The bench gets there in two ways. It fills and drains the whole buffer with auto-advance on, so each pass ends exactly on the wrap. It also loads the pointer two bytes below the top, then writes three bytes and reads them back across the boundary. The pointer registers are read back after each wrap.

// File: rtl/bufram_ptr_pkg.sv
package bufram_ptr_pkg;

  // register locations on the host bus
  typedef enum logic [1:0] {
    SEL_PTR_HI = 2'd0,
    SEL_PTR_LO = 2'd1,
    SEL_DATA   = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic hiWr;    // load upper pointer byte and mode flags
    logic loWr;    // load lower pointer byte
    logic ramWr;   // store window byte at pointer
    logic ptrInc;  // advance pointer by one
    logic fetch;   // copy RAM[pointer] into holding register
  } ptrStrobes_t;

endpackage

// File: rtl/bufram_ptr_ctrl.sv
module bufram_ptr_ctrl
  import bufram_ptr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regAddr,
  input  logic        regRd,
  input  logic        regWr,
  input  logic        dirRead,
  input  logic        autoInc,
  output ptrStrobes_t strobes,
  output logic        fetchPend
);

  logic selHi;
  logic selLo;
  logic selData;
  logic dataWrOk;
  logic dataRdOk;

  always_comb begin
    selHi    = (regAddr == SEL_PTR_HI);
    selLo    = (regAddr == SEL_PTR_LO);
    selData  = (regAddr == SEL_DATA);
    // a window access only counts when it matches the latched direction
    dataWrOk = regWr && selData && !dirRead;
    dataRdOk = regRd && !regWr && selData && dirRead;

    strobes.hiWr   = regWr && selHi;
    strobes.loWr   = regWr && selLo;
    strobes.ramWr  = dataWrOk;
    strobes.ptrInc = autoInc && (dataWrOk || dataRdOk);
    strobes.fetch  = fetchPend;
  end

  // a fetch is owed after a pointer load or an advancing read in read direction
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchPend <= 1'b0;
    end else begin
      fetchPend <= (regWr && selLo && dirRead) || (dataRdOk && autoInc);
    end
  end

endmodule

// File: rtl/bufram_ptr_datapath.sv
module bufram_ptr_datapath
  import bufram_ptr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  ptrStrobes_t       strobes,
  output logic [DATA_W-1:0] regRdata,
  output logic [ADDR_W-1:0] ptrQ,
  output logic              dirRead,
  output logic              autoInc,
  output logic [DATA_W-1:0] holdQ
);

  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int DIR_BIT = DATA_W - 1;
  localparam int INC_BIT = DATA_W - 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] hiView;
  logic [DATA_W-1:0] loView;

  // pointer and mode flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ    <= '0;
      dirRead <= 1'b0;
      autoInc <= 1'b0;
    end else begin
      if (strobes.hiWr) begin
        ptrQ[ADDR_W-1:DATA_W] <= regWdata[HI_W-1:0];
        dirRead               <= regWdata[DIR_BIT];
        autoInc               <= regWdata[INC_BIT];
      end else if (strobes.loWr) begin
        ptrQ[DATA_W-1:0] <= regWdata;
      end else if (strobes.ptrInc) begin
        ptrQ <= ptrQ + 1'b1;
      end
    end
  end

  // buffer RAM, synchronous write
  always_ff @(posedge clk) begin
    if (strobes.ramWr) begin
      mem[ptrQ] <= regWdata;
    end
  end

  // read prefetch into holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ <= '0;
    end else if (strobes.fetch) begin
      holdQ <= mem[ptrQ];
    end
  end

  always_comb begin
    hiView               = '0;
    hiView[DIR_BIT]      = dirRead;
    hiView[INC_BIT]      = autoInc;
    hiView[HI_W-1:0]     = ptrQ[ADDR_W-1:DATA_W];
    loView               = ptrQ[DATA_W-1:0];
  end

  always_comb begin
    unique case (regAddr)
      SEL_PTR_HI: regRdata = hiView;
      SEL_PTR_LO: regRdata = loView;
      SEL_DATA:   regRdata = holdQ;
      default:    regRdata = '0;
    endcase
  end

endmodule

// File: rtl/bufram_ptr_port.sv
module bufram_ptr_port
  import bufram_ptr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regRd,
  input  logic              regWr,
  output logic [DATA_W-1:0] regRdata
);

  ptrStrobes_t       strobes;
  logic [ADDR_W-1:0] ptrQ;
  logic              dirRead;
  logic              autoInc;
  logic [DATA_W-1:0] holdQ;
  logic              fetchPend;

  bufram_ptr_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regRd     (regRd),
    .regWr     (regWr),
    .dirRead   (dirRead),
    .autoInc   (autoInc),
    .strobes   (strobes),
    .fetchPend (fetchPend)
  );

  bufram_ptr_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .strobes  (strobes),
    .regRdata (regRdata),
    .ptrQ     (ptrQ),
    .dirRead  (dirRead),
    .autoInc  (autoInc),
    .holdQ    (holdQ)
  );

endmodule

// File: rtl/bufram_ptr_port_chk.sv
module bufram_ptr_port_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              regRd,
  input logic              regWr,
  input logic [DATA_W-1:0] regRdata,
  input logic [ADDR_W-1:0] ptrQ,
  input logic              dirRead,
  input logic              autoInc,
  input logic [DATA_W-1:0] holdQ,
  input logic              fetchPend
);

  localparam int HI_W = ADDR_W - DATA_W;

  // R2: upper pointer write lands in pointer and mode flags
  a_r2_hi_fields: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 2'd0) |=>
      (ptrQ[ADDR_W-1:DATA_W] == $past(regWdata[HI_W-1:0])) &&
      (dirRead == $past(regWdata[DATA_W-1])) &&
      (autoInc == $past(regWdata[DATA_W-2])));

  // R3: reserved bits read zero
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd0) |-> (regRdata[DATA_W-3:HI_W] == '0));

  // R5, R9: advancing window write moves pointer by one, wrapping
  a_r5_write_advance: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 2'd2 && !dirRead && autoInc) |=>
      (ptrQ == ADDR_W'($past(ptrQ) + 1'b1)));

  // R6: pointer load in read direction owes a fetch
  a_r6_prefetch_owed: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 2'd1 && dirRead) |=> fetchPend);

  // R7: window read returns the holding register
  a_r7_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd2) |-> (regRdata == holdQ));

  // R8: window access without auto-advance keeps pointer
  a_r8_ptr_fixed: assert property (@(posedge clk) disable iff (!rstN)
    ((regWr || regRd) && regAddr == 2'd2 && !autoInc) |=> $stable(ptrQ));

  // R10: window write in read direction does not move pointer
  a_r10_wrong_dir: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 2'd2 && dirRead) |=> $stable(ptrQ));

endmodule

bind bufram_ptr_port bufram_ptr_port_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWdata  (regWdata),
  .regRd     (regRd),
  .regWr     (regWr),
  .regRdata  (regRdata),
  .ptrQ      (ptrQ),
  .dirRead   (dirRead),
  .autoInc   (autoInc),
  .holdQ     (holdQ),
  .fetchPend (fetchPend)
);

// File: tb/bufram_ptr_port_tb.sv
module bufram_ptr_port_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = 2'd3;
  logic [7:0] regWdata = 8'h00;
  logic       regRd = 1'b0;
  logic       regWr = 1'b0;
  logic [7:0] regRdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bufram_ptr_port dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRd    (regRd),
    .regWr    (regWr),
    .regRdata (regRdata)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + (a >> 8) * 11 + 5) & 255);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr  = a;
    regWdata = d;
    regWr    = 1'b1;
    @(negedge clk);
    regWr    = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    regRd   = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd   = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] w0;
    logic [7:0] w1;
    logic [7:0] w2;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(2'd0, d); check("R1 hi after reset", d, 8'h00);
    busRead(2'd1, d); check("R1 lo after reset", d, 8'h00);

    // R2, R3 sweep of every upper byte value
    for (int v = 0; v < 256; v++) begin
      busWrite(2'd0, 8'(v));
      busRead(2'd0, d);
      check("R2 R3 hi readback", d, {8'(v) & 8'hC7});
    end
    // R4 sweep of every lower byte value
    for (int v = 0; v < 256; v++) begin
      busWrite(2'd1, 8'(v));
      busRead(2'd1, d);
      check("R4 lo readback", d, 8'(v));
    end

    // R5 fill whole buffer, write direction, auto-advance
    busWrite(2'd0, 8'h40);
    busWrite(2'd1, 8'h00);
    for (int a = 0; a < 2048; a++) busWrite(2'd2, pat(a));
    busRead(2'd0, d); check("R9 hi after fill wrap", d, 8'h40);
    busRead(2'd1, d); check("R9 lo after fill wrap", d, 8'h00);

    // R6, R7 drain whole buffer, read direction, auto-advance
    busWrite(2'd0, 8'hC0);
    busWrite(2'd1, 8'h00);
    for (int a = 0; a < 2048; a++) begin
      busRead(2'd2, d);
      check("R6 R7 R5 sequential read", d, pat(a));
    end
    busRead(2'd0, d); check("R9 hi after drain wrap", d, 8'hC0);
    busRead(2'd1, d); check("R9 lo after drain wrap", d, 8'h00);

    // R8 reads without auto-advance
    busWrite(2'd0, 8'h85);
    busWrite(2'd1, 8'h12);
    for (int k = 0; k < 3; k++) begin
      busRead(2'd2, d);
      check("R8 repeated read", d, pat(12'h512));
    end
    busRead(2'd1, d); check("R8 lo fixed after reads", d, 8'h12);

    // R10 write in read direction ignored
    busWrite(2'd2, 8'hAA);
    busRead(2'd1, d); check("R10 lo after ignored write", d, 8'h12);
    busWrite(2'd1, 8'h12);
    busRead(2'd2, d); check("R10 RAM after ignored write", d, pat(12'h512));

    // R10 read in write direction does not move pointer
    busWrite(2'd0, 8'h45);
    busWrite(2'd1, 8'h20);
    busRead(2'd2, d);
    busRead(2'd1, d); check("R10 lo after wrong-dir read", d, 8'h20);

    // R8 writes without auto-advance overwrite one location
    busWrite(2'd0, 8'h03);
    busWrite(2'd1, 8'hFF);
    busWrite(2'd2, 8'h11);
    busWrite(2'd2, 8'h22);
    busRead(2'd1, d); check("R8 lo fixed after writes", d, 8'hFF);
    busRead(2'd0, d); check("R8 hi fixed after writes", d, 8'h03);
    busWrite(2'd0, 8'h83);
    busWrite(2'd1, 8'hFF);
    busRead(2'd2, d); check("R8 R5 last write kept", d, 8'h22);
    busWrite(2'd1, 8'hFE);
    busRead(2'd2, d); check("R5 neighbour untouched", d, pat(12'h3FE));

    // R9 wrap during writes then reads across the top
    w0 = 8'h5A; w1 = 8'hC3; w2 = 8'h0F;
    busWrite(2'd0, 8'h47);
    busWrite(2'd1, 8'hFE);
    busWrite(2'd2, w0);
    busWrite(2'd2, w1);
    busWrite(2'd2, w2);
    busRead(2'd0, d); check("R9 hi after write wrap", d, 8'h40);
    busRead(2'd1, d); check("R9 lo after write wrap", d, 8'h01);
    busWrite(2'd0, 8'hC7);
    busWrite(2'd1, 8'hFE);
    busRead(2'd2, d); check("R9 read 0x7FE", d, w0);
    busRead(2'd2, d); check("R9 read 0x7FF", d, w1);
    busRead(2'd2, d); check("R9 read 0x000 after wrap", d, w2);
    busRead(2'd2, d); check("R9 read 0x001", d, pat(1));
    busRead(2'd0, d); check("R9 hi after read wrap", d, 8'hC0);
    busRead(2'd1, d); check("R9 lo after read wrap", d, 8'h02);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule